// File: doc/BRIEF.md
# Two-Wire DAC Register Controller

This block is the digital front end of a 10-bit voltage DAC that listens on a two-wire serial bus as a receive-only target. A fast system clock oversamples the bus clock and data lines. The block finds bus START and STOP conditions, shifts in bytes on rising clock edges and acknowledges by enabling an open-drain pull-down on the data line. It answers two addresses. The first is its own address, a fixed 4-bit prefix followed by three strap pins. The second is a shared synchronisation address that many converters on one bus can watch.

A full transfer carries a command byte, a low data byte and a high data byte. A transfer may also end early, after the command byte alone. The received values land in an input register stage. A second output stage drives the converter: the active code, the reference choice and the power-down request. The output stage normally loads at STOP. When the command byte asks for synchronous mode, it loads only when a quick command arrives on the shared address, so several converters can change together. The same quick command with its direction bit low clears every register.

Top module: `twdac_ctrl`

## Requirements
- R1: After reset, dac_code is 0, ref_int is 0, pwr_down is 0 and sda_pull is 0.
- R2: A first byte of {ADDR_HI (default 4'b0100), addr_sel[2], addr_sel[1], addr_sel[0], direction 0} is acknowledged. An acknowledge holds sda_pull at 1 for the whole high phase of the ninth SCL pulse. The command, low and high data bytes that follow are each acknowledged in the same way.
- R3: A first byte whose upper 7 bits match neither address, or that carries the own address with direction 1, gets no acknowledge. Later bytes up to the next START are not acknowledged either, and the outputs do not change.
- R4: With command bit 0 clear, a complete transfer changes no output before STOP. At STOP, dac_code becomes {high byte bits 1..0, low byte}, ref_int becomes command bit 2 and pwr_down becomes command bit 1.
- R5: Command bits 7..3 and high-byte bits 7..2 have no effect on any output.
- R6: With command bit 0 set, STOP leaves dac_code and ref_int unchanged. The first byte 1111110 followed by direction 1 is acknowledged, and the outputs take the input values on the rising SCL edge of that acknowledge.
- R7: The same update quick command has no effect on the outputs while command bit 0 is clear.
- R8: The first byte 1111110 followed by direction 0 is acknowledged and clears every input and output register on the acknowledge rising edge, whatever command bit 0 holds.
- R9: A START or STOP after the command acknowledge but before the high-byte acknowledge discards both data bytes and keeps the command byte.
- R10: A START or STOP before the command acknowledge discards the partial command byte.
- R11: While pwr_down is 1, dac_code keeps the latched code. It still shows that code after a later STOP clears pwr_down with no new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_sel | input | 3 | Strap pins forming the low three address bits |
| sda_pull | output | 1 | 1 enables the open-drain pull-down on the data line |
| dac_code | output | 10 | Active converter code |
| ref_int | output | 1 | 1 selects the internal reference, 0 the supply |
| pwr_down | output | 1 | 1 requests converter power-down |

## Verification
A wrong bit count or a wrong phase state shows up at once as a missing or misplaced acknowledge on the next ninth clock pulse. The master samples that pull-down twice in every acknowledge high phase. A stale or wrongly committed input register is invisible until the next STOP or synchronous update. For that reason every transfer, including the interrupted ones, is followed by a comparison of the outputs just after the commit point, and for full transfers also just before it. Clear, synchronous update and suppressed update are each checked on the acknowledge edge itself.

// File: rtl/twdac_pkg.sv
package twdac_pkg;

    localparam int BYTE_W = 8;

    // transfer phase of the serial link
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_DLO,
        PH_DHI,
        PH_SKIP
    } phase_t;

    // single-cycle pulses from the link to the register store
    typedef struct packed {
        logic cmd_wr;
        logic lo_wr;
        logic hi_wr;
        logic sync_upd;
        logic sync_clr;
    } strobe_t;

endpackage

// File: rtl/twdac_pinsync.sv
module twdac_pinsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    typedef struct packed {
        logic [STAGES-1:0] scl_c;
        logic [STAGES-1:0] sda_c;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.scl_c = {q.scl_c[STAGES-2:0], scl_in};
        d.sda_c = {q.sda_c[STAGES-2:0], sda_in};
        d.scl_p = q.scl_c[STAGES-1];
        d.sda_p = q.sda_c[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;   // idle bus lines are high
        end else begin
            q <= d;
        end
    end

    assign scl_s    = q.scl_c[STAGES-1];
    assign sda_s    = q.sda_c[STAGES-1];
    assign scl_rise = scl_s & ~q.scl_p;
    assign scl_fall = ~scl_s & q.scl_p;
    assign start_ev = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_ev  = scl_s & q.scl_p & ~q.sda_p & sda_s;

endmodule

// File: rtl/twdac_link.sv
module twdac_link
    import twdac_pkg::*;
#(
    parameter logic [3:0] ADDR_HI   = 4'b0100,
    parameter logic [6:0] SYNC_ADDR = 7'b1111110
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          addr_sel,
    input  logic                scl_s,
    input  logic                sda_s,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_ev,
    input  logic                stop_ev,
    output logic                ack_drive,
    output strobe_t             strb,
    output logic [BYTE_W-1:0]   rx_byte
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        phase_t              ph;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                ack;
        logic                in_ack;
        logic                is_sync;
    } link_t;

    link_t q, d;
    logic [6:0] own_addr;
    logic       accept;

    assign own_addr = {ADDR_HI, addr_sel};

    // accept decision for the byte that just completed
    always_comb begin
        unique case (q.ph)
            PH_ADDR: accept = ((q.sh[7:1] == own_addr) && !q.sh[0]) ||
                              (q.sh[7:1] == SYNC_ADDR);
            PH_CMD,
            PH_DLO,
            PH_DHI:  accept = 1'b1;
            default: accept = 1'b0;
        endcase
    end

    always_comb begin
        d    = q;
        strb = '0;
        if (start_ev) begin
            d.ph      = PH_ADDR;
            d.cnt     = '0;
            d.ack     = 1'b0;
            d.in_ack  = 1'b0;
            d.is_sync = 1'b0;
        end else if (stop_ev) begin
            d.ph      = PH_IDLE;
            d.cnt     = '0;
            d.ack     = 1'b0;
            d.in_ack  = 1'b0;
        end else if (q.ph != PH_IDLE) begin
            if (q.in_ack) begin
                if (scl_rise && q.ack) begin
                    unique case (q.ph)
                        PH_ADDR: begin
                            if (q.is_sync) begin
                                strb.sync_upd = q.sh[0];
                                strb.sync_clr = ~q.sh[0];
                            end
                        end
                        PH_CMD:  strb.cmd_wr = 1'b1;
                        PH_DLO:  strb.lo_wr  = 1'b1;
                        PH_DHI:  strb.hi_wr  = 1'b1;
                        default: ;
                    endcase
                end
                if (scl_fall) begin
                    d.in_ack = 1'b0;
                    d.ack    = 1'b0;
                    d.cnt    = '0;
                    if (!q.ack) begin
                        d.ph = PH_SKIP;
                    end else begin
                        unique case (q.ph)
                            PH_ADDR: d.ph = q.is_sync ? PH_SKIP : PH_CMD;
                            PH_CMD:  d.ph = PH_DLO;
                            PH_DLO:  d.ph = PH_DHI;
                            default: d.ph = PH_SKIP;
                        endcase
                    end
                end
            end else if (scl_rise && (q.cnt < FULL)) begin
                d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                d.cnt = q.cnt + 1'b1;
            end else if (scl_fall && (q.cnt == FULL)) begin
                d.in_ack = 1'b1;
                d.ack    = accept;
                if (q.ph == PH_ADDR) begin
                    d.is_sync = (q.sh[7:1] == SYNC_ADDR);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, cnt: '0, sh: '0, ack: 1'b0, in_ack: 1'b0, is_sync: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ack_drive = q.ack;
    assign rx_byte   = q.sh;

    // R2: once driven, the acknowledge is held through the SCL high phase
    assert_ack_held_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ack && scl_s && !start_ev && !stop_ev) |=> q.ack);

    // R2: the acknowledge is switched on only while SCL is low
    assert_ack_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ack) |-> !scl_s);

    // R6 / R8: at most one register strobe per cycle
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

endmodule

// File: rtl/twdac_store.sv
module twdac_store
    import twdac_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  strobe_t             strb,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic                stop_ev,
    output logic [CODE_W-1:0]   dac_code,
    output logic                ref_int,
    output logic                pwr_down
);

    localparam int HI_W = CODE_W - BYTE_W;

    typedef struct packed {
        logic              in_sy;
        logic              in_sd;
        logic              in_bg;
        logic [BYTE_W-1:0] lo_hold;
        logic [CODE_W-1:0] in_code;
        logic [CODE_W-1:0] out_code;
        logic              out_bg;
        logic              out_sd;
    } store_t;

    store_t q, d;

    always_comb begin
        d = q;
        if (strb.cmd_wr) begin
            d.in_sy = rx_byte[0];
            d.in_sd = rx_byte[1];
            d.in_bg = rx_byte[2];
        end
        if (strb.lo_wr) begin
            d.lo_hold = rx_byte;
        end
        if (strb.hi_wr) begin
            d.in_code = {rx_byte[HI_W-1:0], q.lo_hold};
        end
        if (stop_ev) begin
            d.out_sd = q.in_sd;
            if (!q.in_sy) begin
                d.out_code = q.in_code;
                d.out_bg   = q.in_bg;
            end
        end
        if (strb.sync_upd && q.in_sy) begin
            d.out_code = q.in_code;
            d.out_bg   = q.in_bg;
            d.out_sd   = q.in_sd;
        end
        if (strb.sync_clr) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dac_code = q.out_code;
    assign ref_int  = q.out_bg;
    assign pwr_down = q.out_sd;

    // R4: outputs move only on STOP or a synchronisation command
    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_ev && !strb.sync_upd && !strb.sync_clr) |=>
        ($stable(q.out_code) && $stable(q.out_bg) && $stable(q.out_sd)));

    // R6: synchronous mode blocks the STOP update of code and reference
    assert_sy_blocks_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && q.in_sy) |=> ($stable(q.out_code) && $stable(q.out_bg)));

    // R8: clear empties every stage
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strb.sync_clr |=> (q.out_code == '0 && q.in_code == '0 && !q.in_sy &&
                           !q.out_bg && !q.out_sd));

endmodule

// File: rtl/twdac_ctrl.sv
module twdac_ctrl
    import twdac_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b0100,
    parameter logic [6:0] SYNC_ADDR   = 7'b1111110,
    parameter int         CODE_W      = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        addr_sel,
    output logic              sda_pull,
    output logic [CODE_W-1:0] dac_code,
    output logic              ref_int,
    output logic              pwr_down
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    strobe_t           strb;
    logic [BYTE_W-1:0] rx_byte;

    twdac_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twdac_link #(.ADDR_HI(ADDR_HI), .SYNC_ADDR(SYNC_ADDR)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .ack_drive (sda_pull),
        .strb      (strb),
        .rx_byte   (rx_byte)
    );

    twdac_store #(.CODE_W(CODE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb     (strb),
        .rx_byte  (rx_byte),
        .stop_ev  (stop_ev),
        .dac_code (dac_code),
        .ref_int  (ref_int),
        .pwr_down (pwr_down)
    );

endmodule

// File: tb/twdac_ctrl_test.sv
module twdac_ctrl_test;

    localparam int HALF = 20;
    localparam int QTR  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] addr_sel = 3'b101;
    logic       sda_pull;
    logic [9:0] dac_code;
    logic       ref_int;
    logic       pwr_down;
    logic       sda_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct packed {
        logic [9:0] code;
        logic       bg;
        logic       sd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  cur;
    string cur_tag;

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    twdac_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .addr_sel (addr_sel),
        .sda_pull (sda_pull),
        .dac_code (dac_code),
        .ref_int  (ref_int),
        .pwr_down (pwr_down)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            @(negedge clk);
            cur     = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
            chk({cur_tag, " code"}, int'(dac_code), int'(cur.code));
            chk({cur_tag, " ref"},  int'(ref_int),  int'(cur.bg));
            chk({cur_tag, " pd"},   int'(pwr_down), int'(cur.sd));
        end
    end

    task automatic expect_out(input logic [9:0] c, input logic b, input logic s,
                              input string t);
        exp_t e;
        e.code = c;
        e.bg   = b;
        e.sd   = s;
        exp_q.push_back(e);
        tag_q.push_back(t);
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(QTR);
        m_scl = 1'b1; wt(HALF);
        m_sda = 1'b0; wt(HALF);
        m_scl = 1'b0; wt(QTR);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(QTR);
        m_scl = 1'b1; wt(HALF);
        m_sda = 1'b1; wt(HALF);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    wt(HALF);
        m_scl = 1'b1; wt(HALF);
        m_scl = 1'b0; wt(QTR);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ak);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wt(HALF);
        m_scl = 1'b1; wt(2);
        a1 = ~sda_line; wt(HALF - 4);
        a2 = ~sda_line; wt(2);
        m_scl = 1'b0; wt(QTR);
        ak = a1 & a2;
    endtask

    task automatic byte_ack(input logic [7:0] b, input logic want, input string tag);
        logic a;
        wr_byte(b, a);
        chk(tag, int'(a), int'(want));
    endtask

    function automatic logic [7:0] own_wr();
        return {4'b0100, addr_sel, 1'b0};
    endfunction

    task automatic word(input logic [7:0] cmd, input logic [7:0] lo,
                        input logic [7:0] hi, input string tag);
        bus_start();
        byte_ack(own_wr(), 1'b1, {tag, " addr ack R2"});
        byte_ack(cmd, 1'b1, {tag, " cmd ack R2"});
        byte_ack(lo,  1'b1, {tag, " lo ack R2"});
        byte_ack(hi,  1'b1, {tag, " hi ack R2"});
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R1 reset state
        chk("R1 sda_pull", int'(sda_pull), 0);
        expect_out(10'h000, 1'b0, 1'b0, "R1");

        // R4 / R5: write word, junk in ignored bits
        word(8'hF4, 8'h5A, 8'hFE, "R4");
        expect_out(10'h000, 1'b0, 1'b0, "R4 before stop");
        bus_stop();
        expect_out(10'h25A, 1'b1, 1'b0, "R4 R5 after stop");

        // R3: wrong address and read bit
        bus_start();
        byte_ack(8'h4C, 1'b0, "R3 mismatch no ack");
        byte_ack(8'h00, 1'b0, "R3 later byte no ack");
        bus_stop();
        bus_start();
        byte_ack(8'h4B, 1'b0, "R3 read bit no ack");
        bus_stop();
        expect_out(10'h25A, 1'b1, 1'b0, "R3 unchanged");

        // R9: interrupted after command ack
        bus_start();
        byte_ack(own_wr(), 1'b1, "R9 addr ack");
        byte_ack(8'h00, 1'b1, "R9 cmd ack");
        byte_ack(8'h11, 1'b1, "R9 lo ack");
        bus_start();
        bus_stop();
        expect_out(10'h25A, 1'b0, 1'b0, "R9 cmd kept data dropped");

        // R10: interrupted inside command byte
        bus_start();
        byte_ack(own_wr(), 1'b1, "R10 addr ack");
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        bus_stop();
        expect_out(10'h25A, 1'b0, 1'b0, "R10 partial cmd dropped");

        // R11: shutdown keeps data
        word(8'h02, 8'hFF, 8'h03, "R11");
        bus_stop();
        expect_out(10'h3FF, 1'b0, 1'b1, "R11 shut down");
        bus_start();
        byte_ack(own_wr(), 1'b1, "R11 addr ack");
        byte_ack(8'h00, 1'b1, "R11 cmd ack");
        bus_stop();
        expect_out(10'h3FF, 1'b0, 1'b0, "R11 data retained");

        // R6: synchronous mode
        word(8'h05, 8'hC3, 8'h00, "R6");
        bus_stop();
        expect_out(10'h3FF, 1'b0, 1'b0, "R6 stop blocked");
        bus_start();
        byte_ack(8'hFD, 1'b1, "R6 sync ack");
        expect_out(10'h0C3, 1'b1, 1'b0, "R6 sync update at ack");
        bus_stop();
        expect_out(10'h0C3, 1'b1, 1'b0, "R6 after stop");

        // R7: sync update while synchronous mode is off
        word(8'h00, 8'h55, 8'h01, "R7 first");
        bus_stop();
        expect_out(10'h155, 1'b0, 1'b0, "R7 base");
        word(8'h00, 8'hAA, 8'h00, "R7");
        bus_start();
        byte_ack(8'hFD, 1'b1, "R7 sync ack");
        expect_out(10'h155, 1'b0, 1'b0, "R7 no update");
        bus_stop();
        expect_out(10'h0AA, 1'b0, 1'b0, "R7 R4 stop update");

        // R8: clear
        word(8'h06, 8'hF0, 8'h02, "R8");
        bus_stop();
        expect_out(10'h2F0, 1'b1, 1'b1, "R8 loaded");
        bus_start();
        byte_ack(8'hFC, 1'b1, "R8 clear ack");
        expect_out(10'h000, 1'b0, 1'b0, "R8 cleared at ack");
        bus_stop();
        expect_out(10'h000, 1'b0, 1'b0, "R8 inputs cleared");

        // R2: strap pins change the own address
        addr_sel = 3'b010;
        bus_start();
        byte_ack(8'h4A, 1'b0, "R2 old address rejected");
        bus_stop();
        word(8'h00, 8'h34, 8'h01, "R2 new address");
        bus_stop();
        expect_out(10'h134, 1'b0, 1'b0, "R2 write via new address");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule